// File: doc/BRIEF.md
# Identification Command Mode Controller

This block sits beside the array read path of a multi-bank flash-style memory. It watches the simple write bus for a three-write command sequence: two unlock writes and then an identify command. When the sequence completes, it enters an identification mode tied to the bank named by the third write. While that mode is active, single reads into that bank return small identification and status words instead of array contents. Reads into any other bank still go to the array. A reset command word ends the mode.

The controller refuses to start or continue the sequence while the program/erase engine reports busy. Because the engine is not busy in the read, erase-suspend-read and program-suspend-read states, entry is possible from any of them. While identification mode is on, burst read requests are not granted. The manufacturer code and the boot-block orientation are module parameters. The protection status of the addressed block and the handshaking setting come in on input pins.

Top module: `idm_ctrl`

## Requirements
- R1: After reset, and after any reset applied while the mode is active, `id_mode` is 0 and `id_rvalid` is 0.
- R2: Three writes with no engine-busy enter the mode. Each is compared on its in-bank address (the low ADDR_W-BANK_W bits) and its full data word: 00AAh at 555h, then 0055h at 2AAh, then 0090h at 555h. `id_mode` is 1 from the cycle after the third write. The bank field (top BANK_W address bits) of the third write is latched as the identification bank.
- R3: A write with a wrong address or wrong data at either the second or the third step returns the decoder to idle. The remaining correct steps then do not enter the mode.
- R4: Any write made while `eng_busy` is 1 does not advance the sequence. It sends the decoder back to idle, so entry never completes across a busy write.
- R5: While the mode is active, a read in the identification bank returns a word chosen by its low address byte. Offset 00h gives MFR_CODE (default 00ECh). Offset 01h gives 22FCh when BOOT_TOP is 1 (the default) or 22FDh when it is 0. Offsets 04h to FFh give 0000h.
- R6: Offset 02h returns 0001h when `blk_prot` is 1 and 0000h when it is 0. The in-bank bits above the low byte select the block and are otherwise ignored.
- R7: Offset 03h returns 0000h when `cfg_handshake` is 1 (handshaking) and 0001h when it is 0.
- R8: Any number of identification reads can follow one entry. A write other than the reset command does not leave the mode. Reads to a different bank assert `arr_re` and do not produce `id_rvalid`.
- R9: A write of 00F0h at any address while the mode is active clears `id_mode` on the next cycle. Reads then go to the array again.
- R10: `burst_gnt` follows `burst_req` while `id_mode` is 0 and is held at 0 while `id_mode` is 1.
- R11: `id_rvalid` and `id_rdata` are registered and appear on the cycle after a `bus_re` that hits the identification bank. `arr_re` is combinational, in the same cycle as `bus_re`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address; top BANK_W bits select the bank |
| bus_wdata | input | 16 | Write data (command words) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Single read strobe |
| burst_req | input | 1 | Burst read request from the host |
| eng_busy | input | 1 | Program/erase engine active |
| blk_prot | input | 1 | Protection status of the block at `bus_addr` |
| cfg_handshake | input | 1 | 1 = handshaking mode configured |
| id_mode | output | 1 | Identification mode active |
| id_rvalid | output | 1 | Identification read data valid |
| id_rdata | output | 16 | Identification read data |
| arr_re | output | 1 | Read forwarded to the array |
| burst_gnt | output | 1 | Burst request granted |

## Verification
The bench breaks the unlock sequence in three ways: with a wrong data word, with a wrong address, and with a busy engine at the first or second step. A decoder that resynchronised on the next correct step, or that ignored busy, would then wrongly enter the mode. It reads every offset, both polarities of protection and handshaking, and a read into a foreign bank. A design that ignored the latched bank would return codes where the array should answer. It checks that a non-reset write leaves the mode active, that the reset word exits it, that reset in the middle of the mode clears it, and that burst grants stop only during the mode.

// File: rtl/idm_pkg.sv
package idm_pkg;

  localparam int ID_W = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_UNL1 = 2'd1,
    SEQ_UNL2 = 2'd2,
    SEQ_ACT  = 2'd3
  } seq_st_e;

  localparam logic [ID_W-1:0] CMD_UNL1_D = 16'h00AA;
  localparam logic [ID_W-1:0] CMD_UNL2_D = 16'h0055;
  localparam logic [ID_W-1:0] CMD_IDENT  = 16'h0090;
  localparam logic [ID_W-1:0] CMD_RESET  = 16'h00F0;
  localparam int unsigned     CMD_ADR_A  = 'h555;
  localparam int unsigned     CMD_ADR_B  = 'h2AA;

  localparam logic [7:0] OFS_MFR  = 8'h00;
  localparam logic [7:0] OFS_DEV  = 8'h01;
  localparam logic [7:0] OFS_PROT = 8'h02;
  localparam logic [7:0] OFS_HSK  = 8'h03;

  // Device code: top-boot part ends in C, bottom-boot part ends in D.
  function automatic logic [ID_W-1:0] dev_code(input logic boot_top);
    return boot_top ? 16'h22FC : 16'h22FD;
  endfunction

  // Identification word selected by the low address byte.
  function automatic logic [ID_W-1:0] id_word(
    input logic [7:0]      ofs,
    input logic [ID_W-1:0] mfr,
    input logic            boot_top,
    input logic            prot,
    input logic            hsk
  );
    logic [ID_W-1:0] w;
    case (ofs)
      OFS_MFR:  w = mfr;
      OFS_DEV:  w = dev_code(boot_top);
      OFS_PROT: w = {{(ID_W-1){1'b0}}, prot};
      OFS_HSK:  w = {{(ID_W-1){1'b0}}, ~hsk};
      default:  w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/idm_seq_dec.sv
module idm_seq_dec
  import idm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   wdata,
  input  logic              busy,
  output logic              mode,
  output logic [BANK_W-1:0] bank,
  output logic              enter_evt,
  output logic              exit_evt
);
  localparam int INB_W = ADDR_W - BANK_W;

  seq_st_e st_q, st_d;
  logic [BANK_W-1:0] bank_q;
  logic [INB_W-1:0]  inb;
  logic ok1, ok2, ok3, rst_cmd;

  assign inb     = addr[INB_W-1:0];
  assign ok1     = (inb == INB_W'(CMD_ADR_A)) && (wdata == CMD_UNL1_D);
  assign ok2     = (inb == INB_W'(CMD_ADR_B)) && (wdata == CMD_UNL2_D);
  assign ok3     = (inb == INB_W'(CMD_ADR_A)) && (wdata == CMD_IDENT);
  assign rst_cmd = (wdata == CMD_RESET);

  always_comb begin
    st_d      = st_q;
    enter_evt = 1'b0;
    exit_evt  = 1'b0;
    if (we) begin
      case (st_q)
        SEQ_IDLE: st_d = (!busy && ok1) ? SEQ_UNL1 : SEQ_IDLE;
        SEQ_UNL1: st_d = (!busy && ok2) ? SEQ_UNL2 : SEQ_IDLE;
        SEQ_UNL2: begin
          if (!busy && ok3) begin
            st_d      = SEQ_ACT;
            enter_evt = 1'b1;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        SEQ_ACT: begin
          if (rst_cmd) begin
            st_d     = SEQ_IDLE;
            exit_evt = 1'b1;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      bank_q <= '0;
    end else begin
      st_q <= st_d;
      if (enter_evt) bank_q <= addr[ADDR_W-1 -: BANK_W];
    end
  end

  assign mode = (st_q == SEQ_ACT);
  assign bank = bank_q;

endmodule

// File: rtl/idm_code_rd.sv
module idm_code_rd
  import idm_pkg::*;
#(
  parameter int              BANK_W   = 4,
  parameter logic [ID_W-1:0] MFR_CODE = 16'h00EC,
  parameter bit              BOOT_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [7:0]        rd_ofs,
  input  logic              mode,
  input  logic [BANK_W-1:0] id_bank,
  input  logic              prot,
  input  logic              hsk,
  output logic              hit,
  output logic              rvalid,
  output logic [ID_W-1:0]   rdata
);
  logic [ID_W-1:0] word;

  assign hit  = mode && (rd_bank == id_bank);
  assign word = id_word(rd_ofs, MFR_CODE, BOOT_TOP, prot, hsk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= re && hit;
      if (re && hit) rdata <= word;
    end
  end

endmodule

// File: rtl/idm_ctrl.sv
module idm_ctrl
  import idm_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              BANK_W   = 4,
  parameter logic [ID_W-1:0] MFR_CODE = 16'h00EC,
  parameter bit              BOOT_TOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              burst_req,
  input  logic              eng_busy,
  input  logic              blk_prot,
  input  logic              cfg_handshake,
  output logic              id_mode,
  output logic              id_rvalid,
  output logic [15:0]       id_rdata,
  output logic              arr_re,
  output logic              burst_gnt
);
  logic [BANK_W-1:0] id_bank;
  logic              dec_enter;
  logic              dec_exit;
  logic              id_hit;

  idm_seq_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .busy      (eng_busy),
    .mode      (id_mode),
    .bank      (id_bank),
    .enter_evt (dec_enter),
    .exit_evt  (dec_exit)
  );

  idm_code_rd #(.BANK_W(BANK_W), .MFR_CODE(MFR_CODE), .BOOT_TOP(BOOT_TOP)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .re      (bus_re),
    .rd_bank (bus_addr[ADDR_W-1 -: BANK_W]),
    .rd_ofs  (bus_addr[7:0]),
    .mode    (id_mode),
    .id_bank (id_bank),
    .prot    (blk_prot),
    .hsk     (cfg_handshake),
    .hit     (id_hit),
    .rvalid  (id_rvalid),
    .rdata   (id_rdata)
  );

  assign arr_re    = bus_re && !id_hit;
  assign burst_gnt = burst_req && !id_mode;

endmodule

// File: rtl/idm_ctrl_chk.sv
module idm_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              eng_busy,
  input logic              id_mode,
  input logic              id_rvalid,
  input logic              burst_req,
  input logic              burst_gnt,
  input logic              arr_re,
  input logic [BANK_W-1:0] id_bank,
  input logic              dec_enter,
  input logic              dec_exit
);
  p_rst_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!id_mode && !id_rvalid));

  p_enter_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_enter |=> (id_mode && id_bank == $past(bus_addr[ADDR_W-1 -: BANK_W])));

  p_enter_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(bus_we && bus_wdata == 16'h0090));

  p_busy_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(!eng_busy));

  p_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && !(bus_we && bus_wdata == 16'h00F0)) |=> id_mode);

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && bus_we && bus_wdata == 16'h00F0) |=> !id_mode);

  p_exit_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_exit |-> id_mode);

  p_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode |-> !burst_gnt);

  p_rvalid_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !id_rvalid);

  p_rvalid_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    id_rvalid |-> $past(id_mode && !arr_re));

  p_no_burst_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_mode && burst_req) |-> burst_gnt);
endmodule

bind idm_ctrl idm_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .eng_busy  (eng_busy),
  .id_mode   (id_mode),
  .id_rvalid (id_rvalid),
  .burst_req (burst_req),
  .burst_gnt (burst_gnt),
  .arr_re    (arr_re),
  .id_bank   (id_bank),
  .dec_enter (dec_enter),
  .dec_exit  (dec_exit)
);

// File: tb/idm_ctrl_tb.sv
module idm_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0, burst_req = 1'b0;
  logic        eng_busy = 1'b0, blk_prot = 1'b0, cfg_handshake = 1'b0;
  logic        id_mode, id_rvalid, arr_re, burst_gnt;
  logic [15:0] id_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  idm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .burst_req(burst_req),
    .eng_busy(eng_busy), .blk_prot(blk_prot), .cfg_handshake(cfg_handshake),
    .id_mode(id_mode), .id_rvalid(id_rvalid), .id_rdata(id_rdata),
    .arr_re(arr_re), .burst_gnt(burst_gnt)
  );

  // we re brq busy prot hsk addr wdata | xmode xvalid xdata xarr xgnt
  typedef struct packed {
    logic        we, re, brq, busy, prot, hsk;
    logic [15:0] addr, wd;
    logic        xm, xv;
    logic [15:0] xd;
    logic        xa, xg;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    // R2 entry into bank 3, burst granted before entry (R10)
    '{1,0,1,0,0,0,16'h3555,16'h00AA, 0,0,16'h0000,0,1},
    '{1,0,0,0,0,0,16'h32AA,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h3555,16'h0090, 1,0,16'h0000,0,0},
    // R5/R6/R7 offsets, R10 burst blocked
    '{0,1,1,0,0,0,16'h3000,16'h0000, 1,1,16'h00EC,0,0},
    '{0,1,0,0,0,0,16'h3001,16'h0000, 1,1,16'h22FC,0,0},
    '{0,1,0,0,1,0,16'h3402,16'h0000, 1,1,16'h0001,0,0},
    '{0,1,0,0,0,0,16'h3402,16'h0000, 1,1,16'h0000,0,0},
    '{0,1,0,0,0,1,16'h3003,16'h0000, 1,1,16'h0000,0,0},
    '{0,1,0,0,0,0,16'h3003,16'h0000, 1,1,16'h0001,0,0},
    '{0,1,0,0,0,0,16'h3005,16'h0000, 1,1,16'h0000,0,0},
    // R8 foreign bank goes to array, other writes keep the mode
    '{0,1,0,0,0,0,16'h5000,16'h0000, 1,0,16'h0000,1,0},
    '{1,0,0,0,0,0,16'h3000,16'h1234, 1,0,16'h0000,0,0},
    '{0,1,0,0,0,0,16'h3000,16'h0000, 1,1,16'h00EC,0,0},
    // R9 exit
    '{1,0,0,0,0,0,16'h3777,16'h00F0, 0,0,16'h0000,0,0},
    '{0,1,1,0,0,0,16'h3000,16'h0000, 0,0,16'h0000,1,1},
    // R3 wrong data at step 2
    '{1,0,0,0,0,0,16'h5555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h52AA,16'h0066, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h5555,16'h0090, 0,0,16'h0000,0,0},
    // R3 wrong address at step 2
    '{1,0,0,0,0,0,16'h5555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h5155,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h5555,16'h0090, 0,0,16'h0000,0,0},
    // R3 wrong data at step 3
    '{1,0,0,0,0,0,16'h5555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h52AA,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h5555,16'h0080, 0,0,16'h0000,0,0},
    // R4 busy at step 2
    '{1,0,0,0,0,0,16'h1555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,1,0,0,16'h12AA,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h1555,16'h0090, 0,0,16'h0000,0,0},
    // R4 busy at step 1
    '{1,0,0,1,0,0,16'h1555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h12AA,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h1555,16'h0090, 0,0,16'h0000,0,0},
    // R2/R8 entry into bank 5, bank 3 now array
    '{1,0,0,0,0,0,16'h5555,16'h00AA, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h52AA,16'h0055, 0,0,16'h0000,0,0},
    '{1,0,0,0,0,0,16'h5555,16'h0090, 1,0,16'h0000,0,0},
    '{0,1,0,0,0,0,16'h5F01,16'h0000, 1,1,16'h22FC,0,0},
    '{0,1,0,0,0,0,16'h3001,16'h0000, 1,0,16'h0000,1,0},
    '{0,1,0,0,0,0,16'h5000,16'h0000, 1,1,16'h00EC,0,0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset id_mode", {15'b0, id_mode}, 16'h0);
    chk("R1 reset id_rvalid", {15'b0, id_rvalid}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = VEC[i].we; bus_re = VEC[i].re; burst_req = VEC[i].brq;
      eng_busy = VEC[i].busy; blk_prot = VEC[i].prot; cfg_handshake = VEC[i].hsk;
      bus_addr = VEC[i].addr; bus_wdata = VEC[i].wd;
      #1;
      chk($sformatf("R11/R8 arr_re v%0d", i), {15'b0, arr_re}, {15'b0, VEC[i].xa});
      chk($sformatf("R10 burst_gnt v%0d", i), {15'b0, burst_gnt}, {15'b0, VEC[i].xg});
      @(posedge clk);
      #1;
      bus_we = 1'b0; bus_re = 1'b0; burst_req = 1'b0; eng_busy = 1'b0;
      chk($sformatf("R2/R3/R4/R9 id_mode v%0d", i), {15'b0, id_mode}, {15'b0, VEC[i].xm});
      chk($sformatf("R11 id_rvalid v%0d", i), {15'b0, id_rvalid}, {15'b0, VEC[i].xv});
      if (VEC[i].xv)
        chk($sformatf("R5/R6/R7 id_rdata v%0d", i), id_rdata, VEC[i].xd);
    end

    // R11: valid is a one-cycle pulse
    @(posedge clk); #1;
    chk("R11 id_rvalid pulse ends", {15'b0, id_rvalid}, 16'h0);

    // R10: burst blocked while mode active
    @(negedge clk); burst_req = 1'b1; #1;
    chk("R10 burst blocked in mode", {15'b0, burst_gnt}, 16'h0);
    @(negedge clk); burst_req = 1'b0;

    // R1: reset in the middle of the mode
    rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 mid-mode reset", {15'b0, id_mode}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    bus_re = 1'b1; bus_addr = 16'h5000; #1;
    chk("R1 read after reset goes to array", {15'b0, arr_re}, 16'h1);
    @(negedge clk); bus_re = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule